// File: doc/BRIEF.md
# Indirect Shared Register Access Bridge

This bridge gives a host a path into a bank of shared internal registers through only two host-visible registers: a control word and a data word. The host never talks to the shared bus directly. It writes a register offset and an operation code into the control word. The bridge then issues one request on the shared bus, waits for the acknowledge, and on a read stores the returned value in the data word for the host to fetch. The path needs no request or grant from the main MAC logic, so the shared registers stay reachable while that logic is powered down.

For a write, the host first loads the data word and then writes the control word with the write code. For a read, the host writes the control word with the read code and then reads the data word once the busy flag in the control word has dropped. The control word also reports a sticky error flag. That flag is set when the host triggers a new operation while one is still in flight, or when the shared bus gives no acknowledge within a parameterised number of cycles.

Top module: `indirect_reg_bridge`

## Requirements
- R1: After reset the control word and the data word both read 0, and `shrReq` is low.
- R2: A control-word write stores bits [15:0] as the target offset and bits [29:28] as the operation code. A read of the control word returns those fields in place, bit 31 = busy, bit 30 = error, and zeros elsewhere. Codes 0 and 1 are stored but start no shared-bus request.
- R3: A control-word write with code 2 (read) drives `shrReq` high for exactly one cycle, in the cycle after the write edge. In that cycle `shrWrite` = 0 and `shrOffset` = the stored offset. Offset and direction stay stable until the operation ends.
- R4: A control-word write with code 3 (write) issues the request with `shrWrite` = 1 and `shrWrData` equal to the data word the host stored before the trigger.
- R5: Busy (control bit 31) is set from the trigger edge until the edge that samples `shrAck`. While busy, the data word still reads its previous value.
- R6: For a read, the data word takes `shrRdData` at the edge that samples `shrAck`. It reads the new value from the next cycle on.
- R7: A control-word write with code 2 or 3 while busy is ignored, and the stored offset and code remain. It sets the error flag (bit 30).
- R8: The error flag is sticky. Writing 1 to bit 30 of the control word clears it, and writing 0 there leaves it set.
- R9: If no acknowledge arrives, busy drops at the TIMEOUT-th edge after the trigger edge (default 64) and the error flag is set. For a read, the data word becomes 0xFFFFFFFF.
- R10: Host writes to the data word while busy are ignored.
- R11: `shrAck` while idle has no effect on the data word, busy or the error flag.
- R12: The control word sits at host offset 0x0EC and the data word at 0x0F4. Other offsets read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe |
| hostAddr | input | 12 | Host register offset |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Host read data, combinational from `hostAddr` |
| shrReq | output | 1 | One-cycle shared-bus request |
| shrWrite | output | 1 | Request direction, 1 = write |
| shrOffset | output | 16 | Shared register offset |
| shrWrData | output | 32 | Shared-bus write data |
| shrRdData | input | 32 | Shared-bus read data, valid with `shrAck` |
| shrAck | input | 1 | Shared-bus acknowledge |

## Verification
Some rules are checked by assertions on every cycle:
- the request is a single-cycle pulse that coincides with the rise of busy;
- offset and direction are held while busy;
- an acknowledge ends busy;
- busy never outlasts the timeout window, and an expiry leaves the error flag set.

Other behaviours can only be shown by the bench's directed scenarios:
- the data values moved in each direction;
- the exact edge at which read data lands;
- the control-word layout;
- the ignored triggers and data writes while busy;
- the write-1-to-clear behaviour;
- the 0xFFFFFFFF fill on a timed-out read;
- the address decode.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  typedef enum logic [1:0] {
    OP_IDLE0 = 2'd0,
    OP_IDLE1 = 2'd1,
    OP_READ  = 2'd2,
    OP_WRITE = 2'd3
  } opCode_t;

  // strobes from the sequencer to the register datapath
  typedef struct packed {
    logic ctrlLoad;   // store offset and op code
    logic dataLoad;   // store host data
    logic rdCapture;  // latch shared read data
    logic rdFail;     // fill data with all ones
    logic errSet;
    logic errClr;
  } dpStrobe_t;
endpackage

// File: rtl/ibr_ctrl.sv
module ibr_ctrl
  import ibr_pkg::*;
#(
  parameter int TIMEOUT = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWrite,
  input  logic       dataWrite,
  input  opCode_t    wrOp,
  input  logic       wrErrClr,
  input  logic       curWrite,
  input  logic       shrAck,
  output dpStrobe_t  strobe,
  output logic       busy,
  output logic       shrReq
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  typedef enum logic {ST_IDLE, ST_BUSY} state_t;
  state_t state;
  logic [CNT_W-1:0] waitCnt;
  logic isTrig, start, doneAck, expire;

  assign busy    = (state == ST_BUSY);
  assign isTrig  = (wrOp == OP_READ) || (wrOp == OP_WRITE);
  assign start   = ctrlWrite && !busy && isTrig;
  assign doneAck = busy && shrAck;
  assign expire  = busy && !shrAck && (waitCnt == LAST);

  always_comb begin
    strobe.ctrlLoad  = ctrlWrite && !busy;
    strobe.dataLoad  = dataWrite && !busy;
    strobe.rdCapture = doneAck && !curWrite;
    strobe.rdFail    = expire && !curWrite;
    strobe.errSet    = (ctrlWrite && busy && isTrig) || expire;
    strobe.errClr    = ctrlWrite && wrErrClr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      shrReq  <= 1'b0;
    end else begin
      shrReq <= start;
      if (start) begin
        state   <= ST_BUSY;
        waitCnt <= '0;
      end else if (doneAck || expire) begin
        state <= ST_IDLE;
      end else if (busy) begin
        waitCnt <= waitCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ibr_datapath.sv
module ibr_datapath
  import ibr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFS_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              busy,
  input  logic              selCtrl,
  input  logic              selData,
  input  logic [OFS_W-1:0]  wrOfs,
  input  opCode_t           wrOp,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] shrRdData,
  output logic [DATA_W-1:0] rdData,
  output logic [OFS_W-1:0]  shrOffset,
  output logic [DATA_W-1:0] shrWrData,
  output logic              curWrite,
  output logic              errFlag
);
  localparam int PAD_W = DATA_W - OFS_W - 4;

  logic [OFS_W-1:0]  ofsReg;
  opCode_t           opReg;
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] ctrlWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ofsReg  <= '0;
      opReg   <= OP_IDLE0;
      dataReg <= '0;
      errFlag <= 1'b0;
    end else begin
      if (strobe.ctrlLoad) begin
        ofsReg <= wrOfs;
        opReg  <= wrOp;
      end
      if (strobe.rdFail)         dataReg <= '1;
      else if (strobe.rdCapture) dataReg <= shrRdData;
      else if (strobe.dataLoad)  dataReg <= wrData;
      if (strobe.errSet)         errFlag <= 1'b1;
      else if (strobe.errClr)    errFlag <= 1'b0;
    end
  end

  assign ctrlWord  = {busy, errFlag, opReg, {PAD_W{1'b0}}, ofsReg};
  assign rdData    = selCtrl ? ctrlWord : (selData ? dataReg : '0);
  assign shrOffset = ofsReg;
  assign shrWrData = dataReg;
  assign curWrite  = (opReg == OP_WRITE);
endmodule

// File: rtl/indirect_reg_bridge.sv
module indirect_reg_bridge
  import ibr_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter int          DATA_W   = 32,
  parameter int          OFS_W    = 16,
  parameter int          TIMEOUT  = 64,
  parameter logic [11:0] CTRL_OFS = 12'h0EC,
  parameter logic [11:0] DATA_OFS = 12'h0F4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  output logic              shrReq,
  output logic              shrWrite,
  output logic [OFS_W-1:0]  shrOffset,
  output logic [DATA_W-1:0] shrWrData,
  input  logic [DATA_W-1:0] shrRdData,
  input  logic              shrAck
);
  localparam int OP_LSB = DATA_W - 4;
  localparam int ERR_BIT = DATA_W - 2;

  dpStrobe_t strobe;
  logic selCtrl, selData, busy, errFlag, curWrite;
  opCode_t wrOp;
  logic unusedHostBits;

  assign selCtrl = (hostAddr == ADDR_W'(CTRL_OFS));
  assign selData = (hostAddr == ADDR_W'(DATA_OFS));
  assign wrOp    = opCode_t'(hostWrData[OP_LSB+1:OP_LSB]);
  assign unusedHostBits = ^{hostWrData[DATA_W-1], hostWrData[OP_LSB-1:OFS_W]};
  assign shrWrite = curWrite;

  ibr_ctrl #(.TIMEOUT(TIMEOUT)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .ctrlWrite(hostWrEn && selCtrl),
    .dataWrite(hostWrEn && selData),
    .wrOp(wrOp), .wrErrClr(hostWrData[ERR_BIT]),
    .curWrite(curWrite), .shrAck(shrAck),
    .strobe(strobe), .busy(busy), .shrReq(shrReq)
  );

  ibr_datapath #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busy(busy),
    .selCtrl(selCtrl), .selData(selData),
    .wrOfs(hostWrData[OFS_W-1:0]), .wrOp(wrOp), .wrData(hostWrData),
    .shrRdData(shrRdData), .rdData(hostRdData),
    .shrOffset(shrOffset), .shrWrData(shrWrData),
    .curWrite(curWrite), .errFlag(errFlag)
  );
endmodule

// File: rtl/ibr_checker.sv
module ibr_checker #(
  parameter int TIMEOUT = 64,
  parameter int OFS_W   = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             errFlag,
  input logic             shrReq,
  input logic             shrWrite,
  input logic             shrAck,
  input logic [OFS_W-1:0] shrOffset
);
  localparam int RUN_W = $clog2(TIMEOUT + 2);
  logic [RUN_W-1:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rstN || !busy) busyRun <= '0;
    else                busyRun <= busyRun + 1'b1;
  end

  assert_req_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    shrReq |=> !shrReq);
  assert_req_only_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    shrReq |-> busy);
  assert_rise_has_req_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> shrReq);
  assert_held_fields_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(shrOffset) && $stable(shrWrite)));
  assert_ack_ends_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && shrAck) |=> !busy);
  assert_window_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    int'(busyRun) <= TIMEOUT);
  assert_expire_err_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !shrAck && int'(busyRun) == TIMEOUT - 1) |=> (!busy && errFlag));
endmodule

bind indirect_reg_bridge ibr_checker #(.TIMEOUT(TIMEOUT), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .errFlag(errFlag), .shrReq(shrReq),
  .shrWrite(shrWrite), .shrAck(shrAck), .shrOffset(shrOffset)
);

// File: tb/indirect_reg_bridge_tb.sv
`timescale 1ns/100ps
module indirect_reg_bridge_tb;
  localparam int TMO = 64;
  localparam logic [11:0] A_CTRL = 12'h0EC;
  localparam logic [11:0] A_DATA = 12'h0F4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrEn = 1'b0;
  logic [11:0] hostAddr = '0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic shrReq, shrWrite, shrAck;
  logic [15:0] shrOffset;
  logic [31:0] shrWrData, shrRdData;

  // bench-side shared bus responder
  logic ackReg = 1'b0, pend = 1'b0, noAck = 1'b0, spurAck = 1'b0;
  int ackLat = 2, cd = 0;
  logic [15:0] pOfs;
  logic pWr;
  logic [31:0] pData, rspData = '0, lastWrData = '0;
  logic [15:0] lastWrOfs = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign shrAck    = ackReg | spurAck;
  assign shrRdData = spurAck ? 32'h5555AAAA : rspData;

  indirect_reg_bridge u_dut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .shrReq(shrReq),
    .shrWrite(shrWrite), .shrOffset(shrOffset), .shrWrData(shrWrData),
    .shrRdData(shrRdData), .shrAck(shrAck)
  );

  function automatic logic [31:0] rdVal(input logic [15:0] o);
    return {~o, o};
  endfunction

  always @(posedge clk) begin
    ackReg <= 1'b0;
    if (shrReq && !noAck) begin
      pend <= 1'b1; cd <= ackLat; pOfs <= shrOffset; pWr <= shrWrite; pData <= shrWrData;
    end else if (pend) begin
      if (cd == 0) begin
        ackReg <= 1'b1; pend <= 1'b0; rspData <= rdVal(pOfs);
        if (pWr) begin lastWrOfs <= pOfs; lastWrData <= pData; end
      end else cd <= cd - 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic hostWrite(input logic [11:0] a, input logic [31:0] d);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    step();
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [11:0] a, output logic [31:0] d);
    hostAddr = a; #0.2; d = hostRdData;
  endtask

  task automatic waitIdle();
    logic [31:0] c;
    for (int i = 0; i < 300; i++) begin
      hostRead(A_CTRL, c);
      if (!c[31]) return;
      step();
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    hostRead(A_CTRL, v); chk(v == 0, "R1 ctrl after reset", v, 0);
    hostRead(A_DATA, v); chk(v == 0, "R1 data after reset", v, 0);
    chk(shrReq == 0, "R1 req after reset", 32'(shrReq), 0);
  endtask

  task automatic t_store();
    logic [31:0] v;
    bit sawReq = 0;
    hostWrite(A_CTRL, 32'h1000_1234);
    for (int i = 0; i < 3; i++) begin if (shrReq) sawReq = 1; step(); end
    hostRead(A_CTRL, v); chk(v == 32'h1000_1234, "R2 op1 stored", v, 32'h1000_1234);
    chk(!sawReq, "R2 op1 no request", 32'(sawReq), 0);
    hostWrite(A_CTRL, 32'h0FFF_0042);
    if (shrReq) sawReq = 1;
    step();
    hostRead(A_CTRL, v); chk(v == 32'h0000_0042, "R2 op0 fields masked", v, 32'h0000_0042);
    chk(!sawReq, "R2 op0 no request", 32'(sawReq), 0);
  endtask

  task automatic t_read();
    logic [31:0] v, old;
    ackLat = 3;
    hostWrite(A_DATA, 32'hCAFE_0001);
    old = 32'hCAFE_0001;
    hostWrite(A_CTRL, 32'h2000_0005);
    chk(shrReq && !shrWrite && shrOffset == 16'h5, "R3 read request",
        {shrReq, shrWrite, 14'b0, shrOffset}, 32'h8000_0005);
    hostRead(A_CTRL, v); chk(v[31] == 1, "R5 busy set", v, 32'hA000_0005);
    hostRead(A_DATA, v); chk(v == old, "R5 data holds while busy", v, old);
    step();
    chk(shrReq == 0, "R3 request one cycle", 32'(shrReq), 0);
    for (int i = 0; i < 20 && !shrAck; i++) step();
    hostRead(A_DATA, v); chk(v == old, "R6 data before ack edge", v, old);
    hostRead(A_CTRL, v); chk(v[31] == 1, "R5 busy until ack edge", v, 32'hA000_0005);
    step();
    hostRead(A_DATA, v); chk(v == rdVal(16'h5), "R6 data after ack edge", v, rdVal(16'h5));
    hostRead(A_CTRL, v); chk(v == 32'h2000_0005, "R5 busy cleared", v, 32'h2000_0005);
  endtask

  task automatic t_write();
    logic [31:0] v;
    ackLat = 1;
    hostWrite(A_DATA, 32'hDEAD_BEEF);
    hostWrite(A_CTRL, 32'h3000_0007);
    chk(shrReq && shrWrite && shrOffset == 16'h7, "R4 write request",
        {shrReq, shrWrite, 14'b0, shrOffset}, 32'hC000_0007);
    chk(shrWrData == 32'hDEAD_BEEF, "R4 write data", shrWrData, 32'hDEAD_BEEF);
    waitIdle();
    chk(lastWrOfs == 16'h7 && lastWrData == 32'hDEAD_BEEF, "R4 target written",
        lastWrData, 32'hDEAD_BEEF);
    hostRead(A_DATA, v); chk(v == 32'hDEAD_BEEF, "R4 data kept after write", v, 32'hDEAD_BEEF);
  endtask

  task automatic t_overrun();
    logic [31:0] v;
    ackLat = 6;
    hostWrite(A_DATA, 32'h1111_2222);
    hostWrite(A_CTRL, 32'h3000_0003);
    hostWrite(A_CTRL, 32'h2000_0009);
    hostWrite(A_DATA, 32'h0000_0099);
    hostRead(A_CTRL, v); chk(v == 32'hF000_0003, "R7 trigger ignored, error set", v, 32'hF000_0003);
    hostRead(A_DATA, v); chk(v == 32'h1111_2222, "R10 data write ignored", v, 32'h1111_2222);
    chk(shrWrData == 32'h1111_2222, "R10 bus data held", shrWrData, 32'h1111_2222);
    waitIdle();
    chk(lastWrOfs == 16'h3 && lastWrData == 32'h1111_2222, "R7 original op done",
        lastWrData, 32'h1111_2222);
    hostWrite(A_CTRL, 32'h0000_0003);
    hostRead(A_CTRL, v); chk(v[30] == 1, "R8 write 0 keeps error", v, 32'h4000_0003);
    hostWrite(A_CTRL, 32'h4000_0000);
    hostRead(A_CTRL, v); chk(v == 0, "R8 write 1 clears error", v, 0);
  endtask

  task automatic t_timeout();
    logic [31:0] v;
    noAck = 1;
    hostWrite(A_CTRL, 32'h2000_0004);
    for (int i = 0; i < TMO - 1; i++) step();
    hostRead(A_CTRL, v); chk(v[31] == 1, "R9 busy before timeout", v, 32'hA000_0004);
    step();
    hostRead(A_CTRL, v); chk(v == 32'h6000_0004, "R9 timeout ends, error set", v, 32'h6000_0004);
    hostRead(A_DATA, v); chk(v == 32'hFFFF_FFFF, "R9 read fill", v, 32'hFFFF_FFFF);
    noAck = 0;
    hostWrite(A_CTRL, 32'h4000_0000);
  endtask

  task automatic t_spur();
    logic [31:0] v;
    hostWrite(A_DATA, 32'h0BAD_F00D);
    hostWrite(A_CTRL, 32'h0000_0011);
    spurAck = 1; step(); step(); spurAck = 0;
    hostRead(A_DATA, v); chk(v == 32'h0BAD_F00D, "R11 idle ack no data change", v, 32'h0BAD_F00D);
    hostRead(A_CTRL, v); chk(v == 32'h0000_0011, "R11 idle ack no flag change", v, 32'h0000_0011);
  endtask

  task automatic t_decode();
    logic [31:0] v;
    hostWrite(12'h0F0, 32'h3000_0001);
    chk(shrReq == 0, "R12 stray write no request", 32'(shrReq), 0);
    hostWrite(12'h000, 32'hFFFF_FFFF);
    hostRead(12'h0F0, v); chk(v == 0, "R12 unmapped reads 0", v, 0);
    hostRead(A_CTRL, v); chk(v == 32'h0000_0011, "R12 ctrl untouched", v, 32'h0000_0011);
    hostRead(A_DATA, v); chk(v == 32'h0BAD_F00D, "R12 data untouched", v, 32'h0BAD_F00D);
  endtask

  initial begin
    #((200000) * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step();
    rstN = 1'b1;
    step();
    t_reset();
    t_store();
    t_read();
    t_write();
    t_overrun();
    t_timeout();
    t_spur();
    t_decode();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule